// File: doc/BRIEF.md
# Mode-Sampled Startup Sequencer

This block is the power-up controller of a bus-bridge device. After an active-high reset is released it reads a three-bit mode code once, and that code decides which of four initialization jobs are launched. The jobs are a memory self-test, a clear of the message data area, a clear of the lookup tables together with a reset of the control registers to their defaults, and a copy of the configuration image from nonvolatile storage. The jobs run one at a time through start/done/fail handshakes to external engines. The sequencer itself touches no memory.

When every selected job has finished, the sequencer raises a ready flag and waits in an idle state, where no bus traffic is allowed. A synchronized rising edge on the run input then enables message processing. If a job reports failure, the sequencer records which job failed in a pending-interrupt vector, raises the interrupt line and parks in a safe state. From there only a fresh reset leads back to operation. Host register access is allowed once initialization has ended, whether it ended well or not. The one exception is the mode in which the host port is handed straight to an external controller.

Top module: `startup_sequencer`

## Requirements
- R1: While `rst` is high, and immediately (without waiting for a clock edge) when it rises, `ready_o`, `active_o`, `host_en_o`, `irq_o`, `pend_o` and `task_start_o` are all low.
- R2: `mode_i` is captured on the first clock edge after `rst` falls. Changes to `mode_i` at any later time have no effect on which jobs run.
- R3: Job bit positions are: bit 0 memory self-test, bit 1 data-area clear, bit 2 table and register clear, bit 3 nonvolatile load. The self-test runs in modes 2 and 3. The data clear runs in every mode except 4. The table clear runs in modes 0 to 3. The load runs in modes 1, 3, 4, 5 and 7.
- R4: Jobs start in ascending bit order. Each `task_start_o` bit is a single-cycle pulse, at most one bit is high at a time, and the next job starts only after the current job's done input is seen.
- R5: After the last selected job reports done, `ready_o` goes high and stays high until reset, and no further job is started.
- R6: Outside reset, `run_i` passes through a two-flop synchronizer. A low-to-high transition seen while idle sets `active_o`. A `run_i` level that is already high when the idle state is entered does not count.
- R7: If the running job raises its fail input, that job's bit is set in `pend_o`, `irq_o` goes high, `ready_o` stays low, and no later job is started. A fail input seen in the same cycle as the done input takes priority.
- R8: In the safe state, `active_o` never rises whatever `run_i` does, and `pend_o` and `irq_o` hold until the next reset.
- R9: `host_en_o` is high in the idle, active and safe states, and low during reset and initialization. In mode 6 it stays low throughout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| mode_i | input | 3 | Startup mode code, read once after reset release |
| run_i | input | 1 | Asynchronous request to begin message processing |
| task_start_o | output | 4 | One-cycle start pulse per job |
| task_done_i | input | 4 | Per-job completion pulse |
| task_fail_i | input | 4 | Per-job failure pulse |
| ready_o | output | 1 | Initialization completed successfully |
| active_o | output | 1 | Message processing enabled |
| host_en_o | output | 1 | Host access to memory and registers permitted |
| irq_o | output | 1 | Interrupt, high while any pending bit is set |
| pend_o | output | 4 | Pending-interrupt vector, one bit per failed job |

## Verification
Several properties are checked on every cycle: at most one start pulse at a time, no start pulse once ready, active only while ready, ready and interrupt never high together, stickiness of the ready and pending state, and host access only after initialization. Other behaviour needs the bench's scenarios. These are the exact set of jobs chosen for each of the eight modes, their order, and the immunity to mode changes after capture. They also include the refusal of a run level that is already high on entry to idle, and the way a failure cuts the job list short and traps the sequencer until reset.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int unsigned MODE_W    = 3;
  localparam int unsigned NUM_TASKS = 4;
  localparam int unsigned TASK_IW   = $clog2(NUM_TASKS);

  localparam int unsigned JOB_MEMTEST = 0;
  localparam int unsigned JOB_DCLEAR  = 1;
  localparam int unsigned JOB_TCLEAR  = 2;
  localparam int unsigned JOB_NVLOAD  = 3;

  typedef enum logic [2:0] {
    ST_CAPTURE, ST_INIT, ST_IDLE, ST_ACTIVE, ST_SAFE
  } top_state_e;

  typedef enum logic [1:0] {
    SQ_HALT, SQ_PICK, SQ_WAIT
  } seq_state_e;
endpackage

// File: rtl/run_edge_det.sv
module run_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-1:0], async_i};
  end

  // stage STAGES-1 is the synchronized level, stage STAGES its prior value
  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/task_plan.sv
module task_plan
  import startup_pkg::*;
(
  input  logic [MODE_W-1:0]    mode_i,
  output logic [NUM_TASKS-1:0] mask_o,
  output logic                 bypass_o
);
  always_comb begin
    mask_o              = '0;
    mask_o[JOB_MEMTEST] = (mode_i == 3'd2) || (mode_i == 3'd3);
    mask_o[JOB_DCLEAR]  = (mode_i != 3'd4);
    mask_o[JOB_TCLEAR]  = (mode_i <= 3'd3);
    mask_o[JOB_NVLOAD]  = mode_i[0] || (mode_i == 3'd4);
    bypass_o            = (mode_i == 3'd6);
  end
endmodule

// File: rtl/task_sequencer.sv
module task_sequencer
  import startup_pkg::*;
#(
  parameter int N = NUM_TASKS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] done_i,
  input  logic [N-1:0] fail_i,
  output logic [N-1:0] start_o,
  output logic         finished_o,
  output logic         failed_o,
  output logic [N-1:0] fail_vec_o
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  seq_state_e    sq_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sq_q       <= SQ_HALT;
      idx_q      <= '0;
      start_o    <= '0;
      finished_o <= 1'b0;
      failed_o   <= 1'b0;
      fail_vec_o <= '0;
    end else begin
      start_o    <= '0;
      finished_o <= 1'b0;
      failed_o   <= 1'b0;
      case (sq_q)
        SQ_HALT: begin
          if (go_i) begin
            idx_q <= '0;
            sq_q  <= SQ_PICK;
          end
        end
        SQ_PICK: begin
          if (mask_i[idx_q]) begin
            start_o <= N'(1) << idx_q;
            sq_q    <= SQ_WAIT;
          end else if (idx_q == LAST) begin
            finished_o <= 1'b1;
            sq_q       <= SQ_HALT;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        SQ_WAIT: begin
          // failure wins over a simultaneous done
          if (fail_i[idx_q]) begin
            failed_o   <= 1'b1;
            fail_vec_o <= N'(1) << idx_q;
            sq_q       <= SQ_HALT;
          end else if (done_i[idx_q]) begin
            if (idx_q == LAST) begin
              finished_o <= 1'b1;
              sq_q       <= SQ_HALT;
            end else begin
              idx_q <= idx_q + IW'(1);
              sq_q  <= SQ_PICK;
            end
          end
        end
        default: sq_q <= SQ_HALT;
      endcase
    end
  end
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import startup_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MODE_W-1:0]    mode_i,
  input  logic                 run_i,
  output logic [NUM_TASKS-1:0] task_start_o,
  input  logic [NUM_TASKS-1:0] task_done_i,
  input  logic [NUM_TASKS-1:0] task_fail_i,
  output logic                 ready_o,
  output logic                 active_o,
  output logic                 host_en_o,
  output logic                 irq_o,
  output logic [NUM_TASKS-1:0] pend_o
);
  top_state_e           state_q;
  logic [MODE_W-1:0]    mode_q;
  logic                 go_q;
  logic [NUM_TASKS-1:0] pend_q;
  logic [NUM_TASKS-1:0] plan_mask;
  logic                 plan_bypass;
  logic                 run_rise;
  logic                 seq_fin;
  logic                 seq_flt;
  logic [NUM_TASKS-1:0] seq_fvec;

  task_plan u_plan (
    .mode_i  (mode_q),
    .mask_o  (plan_mask),
    .bypass_o(plan_bypass)
  );

  run_edge_det #(.STAGES(SYNC_STAGES)) u_run (
    .clk    (clk),
    .rst    (rst),
    .async_i(run_i),
    .rise_o (run_rise)
  );

  task_sequencer #(.N(NUM_TASKS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .go_i      (go_q),
    .mask_i    (plan_mask),
    .done_i    (task_done_i),
    .fail_i    (task_fail_i),
    .start_o   (task_start_o),
    .finished_o(seq_fin),
    .failed_o  (seq_flt),
    .fail_vec_o(seq_fvec)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state_q <= ST_CAPTURE;
      mode_q  <= '0;
      go_q    <= 1'b0;
      pend_q  <= '0;
    end else begin
      go_q <= 1'b0;
      case (state_q)
        ST_CAPTURE: begin
          mode_q  <= mode_i;
          go_q    <= 1'b1;
          state_q <= ST_INIT;
        end
        ST_INIT: begin
          if (seq_flt) begin
            pend_q  <= pend_q | seq_fvec;
            state_q <= ST_SAFE;
          end else if (seq_fin) begin
            state_q <= ST_IDLE;
          end
        end
        ST_IDLE:   if (run_rise) state_q <= ST_ACTIVE;
        ST_ACTIVE: state_q <= ST_ACTIVE;
        ST_SAFE:   state_q <= ST_SAFE;
        default:   state_q <= ST_SAFE;
      endcase
    end
  end

  assign ready_o   = (state_q == ST_IDLE) || (state_q == ST_ACTIVE);
  assign active_o  = (state_q == ST_ACTIVE);
  assign host_en_o = (ready_o || (state_q == ST_SAFE)) && !plan_bypass;
  assign irq_o     = |pend_q;
  assign pend_o    = pend_q;
endmodule

// File: rtl/startup_sequencer_chk.sv
module startup_sequencer_chk
  import startup_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_TASKS-1:0] task_start_o,
  input logic                 ready_o,
  input logic                 active_o,
  input logic                 host_en_o,
  input logic                 irq_o,
  input logic [NUM_TASKS-1:0] pend_o
);
  p_start_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(task_start_o));

  p_no_start_when_ready_r5: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> (task_start_o == '0));

  p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  p_active_needs_ready_r6: assert property (@(posedge clk) disable iff (rst)
    active_o |-> ready_o);

  p_fail_excludes_ready_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (!ready_o && !active_o));

  p_safe_holds_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> (irq_o && $stable(pend_o) && !active_o));

  p_host_after_init_r9: assert property (@(posedge clk) disable iff (rst)
    host_en_o |-> (ready_o || irq_o));
endmodule

bind startup_sequencer startup_sequencer_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .task_start_o(task_start_o),
  .ready_o     (ready_o),
  .active_o    (active_o),
  .host_en_o   (host_en_o),
  .irq_o       (irq_o),
  .pend_o      (pend_o)
);

// File: tb/test_startup_sequencer.sv
`timescale 1ns/1ps
module test_startup_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_i = 3'd0;
  logic       run_i = 1'b0;
  logic [3:0] task_start_o;
  logic [3:0] task_done_i = 4'b0;
  logic [3:0] task_fail_i = 4'b0;
  logic       ready_o, active_o, host_en_o, irq_o;
  logic [3:0] pend_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  startup_sequencer i_startup_sequencer (
    .clk(clk), .rst(rst), .mode_i(mode_i), .run_i(run_i),
    .task_start_o(task_start_o), .task_done_i(task_done_i),
    .task_fail_i(task_fail_i), .ready_o(ready_o), .active_o(active_o),
    .host_en_o(host_en_o), .irq_o(irq_o), .pend_o(pend_o)
  );

  // vectors: mode, job to fail (-1 none), expected starts, host, pending
  localparam int NV = 10;
  localparam logic [2:0] V_MODE  [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7, 3'd3, 3'd1};
  localparam int         V_FAIL  [NV] = '{-1, -1, -1, -1, -1, -1, -1, -1, 0, 3};
  localparam logic [3:0] V_START [NV] = '{4'b0110, 4'b1110, 4'b0111, 4'b1111, 4'b1000,
                                          4'b1010, 4'b0010, 4'b1010, 4'b0001, 4'b1110};
  localparam logic       V_HOST  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam logic [3:0] V_PEND  [NV] = '{4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 4'b0, 4'b0001, 4'b1000};

  // job engine model
  int         fail_job = -1;
  int         cur_job = 0;
  int         last_job = -1;
  int         wait_cnt = 0;
  logic [3:0] seen = 4'b0;
  bit         order_err = 1'b0;

  always @(negedge clk) begin
    task_done_i = 4'b0;
    task_fail_i = 4'b0;
    if (rst) begin
      wait_cnt = 0;
    end else if (task_start_o != 4'b0) begin
      if ($countones(task_start_o) != 1) order_err = 1'b1;
      for (int b = 0; b < 4; b++) if (task_start_o[b]) cur_job = b;
      if (cur_job <= last_job) order_err = 1'b1;
      if (wait_cnt != 0) order_err = 1'b1;
      last_job = cur_job;
      seen = seen | task_start_o;
      wait_cnt = 3;
    end else if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        if (cur_job == fail_job) task_fail_i[cur_job] = 1'b1;
        else                     task_done_i[cur_job] = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_end();
    for (int k = 0; k < 300; k++) begin
      if (ready_o || irq_o) break;
      @(negedge clk);
    end
  endtask

  task automatic start_run(input logic [2:0] m, input int fj, input logic run_lvl);
    @(negedge clk);
    rst = 1'b1;
    mode_i = m;
    run_i = run_lvl;
    fail_job = fj;
    seen = 4'b0;
    last_job = -1;
    order_err = 1'b0;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    mode_i = ~m; // captured already; must be ignored (R2)
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    cycles(4);
    check(!ready_o && !active_o && !host_en_o && !irq_o, "R1 reset flags",
          {ready_o, active_o, host_en_o, irq_o}, 0);
    check(pend_o == 4'b0 && task_start_o == 4'b0, "R1 reset vectors",
          {pend_o, task_start_o}, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      start_run(V_MODE[v], V_FAIL[v], 1'b0);
      wait_end();
      cycles(5);
      check(seen == V_START[v], "R2/R3 job set", seen, V_START[v]);
      check(!order_err, "R4 order and single pulse", order_err, 0);
      check(ready_o == (V_FAIL[v] < 0), "R5/R7 ready", ready_o, V_FAIL[v] < 0);
      check(pend_o == V_PEND[v], "R7 pending", pend_o, V_PEND[v]);
      check(irq_o == (V_PEND[v] != 0), "R7 irq", irq_o, V_PEND[v] != 0);
      check(host_en_o == V_HOST[v], "R9 host enable", host_en_o, V_HOST[v]);
      check(!active_o, "R6 idle before run", active_o, 0);
      run_i = 1'b1;
      cycles(6);
      check(active_o == (V_FAIL[v] < 0), "R6/R8 run edge", active_o, V_FAIL[v] < 0);
      check(pend_o == V_PEND[v], "R8 pending held", pend_o, V_PEND[v]);
      run_i = 1'b0;
      cycles(2);
    end

    // R6: run already high when idle is entered
    start_run(3'd6, -1, 1'b1);
    wait_end();
    cycles(10);
    check(ready_o && !active_o, "R6 held run ignored", active_o, 0);
    run_i = 1'b0;
    cycles(4);
    run_i = 1'b1;
    cycles(6);
    check(active_o, "R6 fresh edge", active_o, 1);

    // R1: reset takes effect without a clock edge
    @(negedge clk);
    #1 rst = 1'b1;
    #0.5;
    check(!ready_o && !active_o && !host_en_o, "R1 async reset",
          {ready_o, active_o, host_en_o}, 0);
    run_i = 1'b0;

    // R8: safe left only by reset, then clean run clears pending
    start_run(3'd2, 0, 1'b0);
    wait_end();
    cycles(3);
    check(irq_o && pend_o == 4'b0001, "R7 memtest fail", pend_o, 1);
    for (int t = 0; t < 3; t++) begin
      run_i = 1'b1; cycles(5);
      run_i = 1'b0; cycles(5);
    end
    check(!active_o && !ready_o, "R8 safe trapped", active_o, 0);
    start_run(3'd4, -1, 1'b0);
    wait_end();
    cycles(3);
    check(ready_o && pend_o == 4'b0 && !irq_o, "R8 reset leaves safe", pend_o, 0);
    check(seen == 4'b1000, "R3 mode 4 load only", seen, 4'b1000);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule